// File: doc/BRIEF.md
# EPP Parallel Port Host Controller

This block is the host side of a PC-style parallel port. A CPU reaches it through an eight-location register window addressed by three bits, with byte, 16-bit and 32-bit transfers. Behind the window sit a data latch, a status view of the printer-side inputs, and a control register that drives the handshake lines of a standard printer port.

The same window also carries Enhanced Parallel Port transfers. A write or read at the EPP address location runs one address-strobe handshake on the pins. A transfer at the EPP data location runs one, two or four data-strobe handshakes, least significant byte first. A handshake only starts when the control register holds the one pattern that suits the transfer direction. Any other pattern turns the access into a no-op. A peripheral that does not answer within a programmable number of clock cycles aborts the handshake and sets a sticky timeout flag in the status register. Software clears that flag by writing a one to it.

The CPU side is a request/response port. `cpu_ready` is high only when a request can be accepted. Every accepted request, including writes, ends with a one-cycle `cpu_rvalid` pulse that carries the read data.

Top module: `epp_port_ctrl`

## Requirements
- R1: Only `cpu_addr[2:0]` selects a location: 0 data, 1 status, 2 control, 3 EPP address, 4 EPP data. Reads of locations 5, 6 and 7 return 0xFF, and writes to them change nothing.
- R2: The control register keeps written bits 5:0 (bit5 direction, 1 = input; bit4 interrupt enable; bit3 select; bit2 init; bit1 auto-feed; bit0 strobe). It reads back with bits 7:6 forced to 1. Its reset value is 0x0C, which reads as 0xCC.
- R3: `n_strobe`, `n_autolf` and `n_selin` are the inverse of control bits 0, 1 and 3. `n_init` follows control bit 2. Outside a handshake, `pd_oe` is the inverse of control bit 5.
- R4: A data write drives `pd_out` outside handshakes (reset value 0xFF). A data read returns `pd_in` when control bit5 is 1, and the latch otherwise. Writing the value already held leaves `pd_out` unchanged.
- R5: A status read returns `{st_in[4:0], 2'b00, timeout}`, so the timeout flag sits in bit 0.
- R6: An EPP write runs only when control bits {5,3,2,1,0} equal exactly {0,0,1,0,0} (control & 0x2F == 0x04). Otherwise no strobe falls and nothing changes.
- R7: An EPP read runs only when control & 0x2F == 0x24. Otherwise no strobe falls, and the read returns all ones over the access width (0xFF, 0xFFFF or 0xFFFFFFFF), with zeros above it.
- R8: In an EPP write handshake, `n_write` is low and the byte is on `pd_out` with `pd_oe` high. `n_astrb` (location 3) or `n_dstrb` (location 4) then falls and stays low until `n_wait` is high. After the strobe rises, the handshake ends when `n_wait` is low.
- R9: An EPP read handshake keeps `n_write` high and `pd_oe` low. It captures `pd_in` in the cycle in which `n_wait` is seen high while the strobe is low.
- R10: `cpu_size` 0, 1 and 2 select 1, 2 and 4 bytes. At location 4 an access runs that many data handshakes, taking write bytes from bit 0 upward and placing read bytes from bit 0 upward. Location 3 always moves one byte.
- R11: If `n_wait` does not respond within TMO_CYCLES cycles in either phase, the strobe is released and the timeout flag is set. The remaining bytes of the access are dropped, and read bytes not received stay 0xFF.
- R12: A status write with bit0 = 1 clears the timeout flag. A status write with bit0 = 0 leaves it as it is.
- R13: `cpu_ready` is low from the cycle after acceptance until the response. `cpu_rvalid` lasts exactly one cycle for every accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register location |
| cpu_size | input | 2 | 0 byte, 1 half, 2 word |
| cpu_wdata | input | BUS_W | Write data |
| cpu_ready | output | 1 | Idle, able to accept |
| cpu_rvalid | output | 1 | One-cycle response pulse |
| cpu_rdata | output | BUS_W | Read data, valid with `cpu_rvalid` |
| pd_out | output | 8 | Data lines out |
| pd_oe | output | 1 | Data line output enable |
| pd_in | input | 8 | Data lines in |
| st_in | input | 5 | Status inputs for status bits 7:3 |
| n_strobe | output | 1 | Printer strobe, active low |
| n_autolf | output | 1 | Auto feed, active low |
| n_init | output | 1 | Initialise, active low |
| n_selin | output | 1 | Select in, active low |
| n_write | output | 1 | EPP write indication, active low |
| n_dstrb | output | 1 | EPP data strobe, active low |
| n_astrb | output | 1 | EPP address strobe, active low |
| n_wait | input | 1 | EPP peripheral handshake |

## Verification
The bench walks the control register through patterns that differ from the two gate patterns by a single bit. A design with a loose mask would then run a handshake it should have skipped, and the peripheral model's strobe counter would show it. Multi-byte transfers are checked byte by byte against the peripheral's log, which catches a reversed lane order or a dropped byte. A mute peripheral exercises the timeout. A design that hangs, fails to set the flag, or clears it on a write of zero is caught by the status readback that follows. Randomised control values mixed with single-byte EPP reads and writes compare every result against the gate rule worked out in the bench.

// File: rtl/epp_port_pkg.sv
package epp_port_pkg;
   localparam logic [2:0] OFF_DATA  = 3'd0;
   localparam logic [2:0] OFF_STAT  = 3'd1;
   localparam logic [2:0] OFF_CTRL  = 3'd2;
   localparam logic [2:0] OFF_EADDR = 3'd3;
   localparam logic [2:0] OFF_EDATA = 3'd4;

   localparam int CB_DIR = 5;
   localparam int CB_SEL = 3;
   localparam int CB_INI = 2;
   localparam int CB_ALF = 1;
   localparam int CB_STB = 0;

   localparam logic [5:0] GATE_MASK = 6'h2F;
   localparam logic [5:0] GATE_WR   = 6'h04;
   localparam logic [5:0] GATE_RD   = 6'h24;
   localparam logic [5:0] CTRL_RST  = 6'h0C;
   localparam logic [7:0] DATA_RST  = 8'hFF;

   typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_RESP} seq_st_e;
   typedef enum logic [1:0] {CY_IDLE, CY_SETUP, CY_STRB, CY_REL} cyc_st_e;
endpackage

// File: rtl/epp_port_regs.sv
module epp_port_regs
   import epp_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_off,
   input  logic [7:0] wr_byte,
   input  logic       tmo_set,
   output logic [7:0] data_q,
   output logic [5:0] ctrl_q,
   output logic       tmo_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= DATA_RST;
         ctrl_q <= CTRL_RST;
         tmo_q  <= 1'b0;
      end else begin
         if (wr_en && wr_off == OFF_DATA && wr_byte != data_q) data_q <= wr_byte;
         if (wr_en && wr_off == OFF_CTRL) ctrl_q <= wr_byte[5:0];
         if (tmo_set) tmo_q <= 1'b1;
         else if (wr_en && wr_off == OFF_STAT && wr_byte[0]) tmo_q <= 1'b0;
      end
   end

   assert_tmo_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_q) |-> $past(tmo_set));
   assert_tmo_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmo_q) |-> ($past(wr_en) && $past(wr_off) == OFF_STAT && $past(wr_byte[0])));
endmodule

// File: rtl/epp_byte_cycle.sv
module epp_byte_cycle
   import epp_port_pkg::*;
#(
   parameter int TMO_CYCLES = 2000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       is_addr,
   input  logic       is_read,
   input  logic [7:0] wbyte,
   input  logic       n_wait,
   input  logic [7:0] pd_in,
   output logic       busy,
   output logic       drive,
   output logic       n_write,
   output logic       n_dstrb,
   output logic       n_astrb,
   output logic [7:0] pd_out,
   output logic [7:0] rbyte,
   output logic       done,
   output logic       fail
);
   localparam int CW = $clog2(TMO_CYCLES + 1);
   localparam logic [CW-1:0] LIM = CW'(TMO_CYCLES - 1);

   cyc_st_e        st_q;
   logic           rd_q, adr_q;
   logic [7:0]     wb_q;
   logic [CW-1:0]  cnt_q;
   logic           strb_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= CY_IDLE;
         rd_q  <= 1'b0;
         adr_q <= 1'b0;
         wb_q  <= 8'h00;
         cnt_q <= '0;
         rbyte <= 8'hFF;
         done  <= 1'b0;
         fail  <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         case (st_q)
            CY_IDLE: if (start) begin
               rd_q  <= is_read;
               adr_q <= is_addr;
               wb_q  <= wbyte;
               cnt_q <= '0;
               st_q  <= CY_SETUP;
            end
            CY_SETUP: begin
               cnt_q <= '0;
               st_q  <= CY_STRB;
            end
            CY_STRB: begin
               if (n_wait) begin
                  rbyte <= pd_in;
                  cnt_q <= '0;
                  st_q  <= CY_REL;
               end else if (cnt_q == LIM) begin
                  fail <= 1'b1;
                  st_q <= CY_IDLE;
               end else cnt_q <= cnt_q + 1'b1;
            end
            CY_REL: begin
               if (!n_wait) begin
                  done <= 1'b1;
                  st_q <= CY_IDLE;
               end else if (cnt_q == LIM) begin
                  fail <= 1'b1;
                  st_q <= CY_IDLE;
               end else cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= CY_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != CY_IDLE);
   assign strb_on = (st_q == CY_STRB);
   assign n_dstrb = !(strb_on && !adr_q);
   assign n_astrb = !(strb_on && adr_q);
   assign n_write = !(busy && !rd_q);
   assign drive   = busy && !rd_q;
   assign pd_out  = wb_q;

   assert_done_after_wait_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !$past(n_wait));
   assert_fail_at_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> ($past(cnt_q) == LIM));
   assert_no_double_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!n_dstrb && !n_astrb));
endmodule

// File: rtl/epp_port_ctrl.sv
module epp_port_ctrl
   import epp_port_pkg::*;
#(
   parameter int BUS_W      = 32,
   parameter int TMO_CYCLES = 2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [2:0]       cpu_addr,
   input  logic [1:0]       cpu_size,
   input  logic [BUS_W-1:0] cpu_wdata,
   output logic             cpu_ready,
   output logic             cpu_rvalid,
   output logic [BUS_W-1:0] cpu_rdata,
   output logic [7:0]       pd_out,
   output logic             pd_oe,
   input  logic [7:0]       pd_in,
   input  logic [4:0]       st_in,
   output logic             n_strobe,
   output logic             n_autolf,
   output logic             n_init,
   output logic             n_selin,
   output logic             n_write,
   output logic             n_dstrb,
   output logic             n_astrb,
   input  logic             n_wait
);
   localparam int NB   = BUS_W / 8;
   localparam int IDXW = (NB > 1) ? $clog2(NB) : 1;

   if (!(BUS_W == 8 || BUS_W == 16 || BUS_W == 32)) begin : g_bad_width
      $error("BUS_W must be 8, 16 or 32");
   end
   if (TMO_CYCLES < 2) begin : g_bad_tmo
      $error("TMO_CYCLES must be at least 2");
   end

   seq_st_e          st_q;
   logic             we_q, adr_q;
   logic [IDXW-1:0]  idx_q, last_q;
   logic [BUS_W-1:0] wd_q, rd_q;

   logic [7:0] data_q;
   logic [5:0] ctrl_q;
   logic       tmo_q, tmo_set;

   logic       acc, is_epp, gate;
   logic [3:0] nb_raw, nb_acc;
   logic [NB-1:0]    lane_on;
   logic [BUS_W-1:0] acc_mask;
   logic [7:0] imm_byte;

   logic       cyc_start, cyc_busy, cyc_drive, cyc_done, cyc_fail;
   logic [7:0] cyc_pd, cyc_rbyte, cyc_wbyte;

   assign acc    = cpu_req && (st_q == ST_IDLE);
   assign is_epp = (cpu_addr == OFF_EADDR) || (cpu_addr == OFF_EDATA);
   assign gate   = cpu_we ? ((ctrl_q & GATE_MASK) == GATE_WR)
                          : ((ctrl_q & GATE_MASK) == GATE_RD);

   always_comb begin
      case (cpu_size)
         2'd0:    nb_raw = 4'd1;
         2'd1:    nb_raw = 4'd2;
         default: nb_raw = 4'd4;
      endcase
      if (cpu_addr != OFF_EDATA) nb_raw = 4'd1;
      nb_acc = (nb_raw > 4'(NB)) ? 4'(NB) : nb_raw;
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane_on[g]           = (nb_acc > 4'(g));
      assign acc_mask[g*8 +: 8]   = {8{lane_on[g]}};
   end

   always_comb begin
      case (cpu_addr)
         OFF_DATA: imm_byte = ctrl_q[CB_DIR] ? pd_in : data_q;
         OFF_STAT: imm_byte = {st_in, 2'b00, tmo_q};
         OFF_CTRL: imm_byte = {2'b11, ctrl_q};
         default:  imm_byte = 8'hFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         we_q   <= 1'b0;
         adr_q  <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         wd_q   <= '0;
         rd_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (acc) begin
               we_q   <= cpu_we;
               adr_q  <= (cpu_addr == OFF_EADDR);
               wd_q   <= cpu_wdata;
               idx_q  <= '0;
               last_q <= IDXW'(nb_acc - 4'd1);
               if (is_epp) begin
                  rd_q <= cpu_we ? '0 : acc_mask;
                  st_q <= gate ? ST_LAUNCH : ST_RESP;
               end else begin
                  rd_q <= cpu_we ? '0 : BUS_W'(imm_byte);
                  st_q <= ST_RESP;
               end
            end
            ST_LAUNCH: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (cyc_fail) st_q <= ST_RESP;
               else if (cyc_done) begin
                  if (!we_q) rd_q[{idx_q, 3'b000} +: 8] <= cyc_rbyte;
                  if (idx_q == last_q) st_q <= ST_RESP;
                  else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= ST_LAUNCH;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign tmo_set   = (st_q == ST_WAIT) && cyc_fail;
   assign cyc_start = (st_q == ST_LAUNCH);
   assign cyc_wbyte = wd_q[{idx_q, 3'b000} +: 8];

   epp_port_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc && cpu_we && !is_epp),
      .wr_off  (cpu_addr),
      .wr_byte (cpu_wdata[7:0]),
      .tmo_set (tmo_set),
      .data_q  (data_q),
      .ctrl_q  (ctrl_q),
      .tmo_q   (tmo_q)
   );

   epp_byte_cycle #(.TMO_CYCLES(TMO_CYCLES)) u_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cyc_start),
      .is_addr (adr_q),
      .is_read (!we_q),
      .wbyte   (cyc_wbyte),
      .n_wait  (n_wait),
      .pd_in   (pd_in),
      .busy    (cyc_busy),
      .drive   (cyc_drive),
      .n_write (n_write),
      .n_dstrb (n_dstrb),
      .n_astrb (n_astrb),
      .pd_out  (cyc_pd),
      .rbyte   (cyc_rbyte),
      .done    (cyc_done),
      .fail    (cyc_fail)
   );

   assign cpu_ready  = (st_q == ST_IDLE);
   assign cpu_rvalid = (st_q == ST_RESP);
   assign cpu_rdata  = rd_q;

   assign pd_out   = cyc_busy ? cyc_pd : data_q;
   assign pd_oe    = cyc_busy ? cyc_drive : !ctrl_q[CB_DIR];
   assign n_strobe = !ctrl_q[CB_STB];
   assign n_autolf = !ctrl_q[CB_ALF];
   assign n_init   = ctrl_q[CB_INI];
   assign n_selin  = !ctrl_q[CB_SEL];

   assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cpu_we && is_epp && !gate) |=> (cpu_rvalid && n_dstrb && n_astrb));
   assert_gate_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cpu_we && is_epp && !gate) |=> (cpu_rvalid && n_dstrb && n_astrb));
   assert_read_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((!n_dstrb || !n_astrb) && n_write) |-> !pd_oe);
   assert_busy_stalls_R13: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_busy |-> !cpu_ready);
   assert_single_resp_R13: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |=> !cpu_rvalid);
endmodule

// File: tb/epp_port_ctrl_tb.sv
`timescale 1ns/100ps
module epp_port_ctrl_tb;
   localparam int TMO = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [2:0]  cpu_addr = 3'd0;
   logic [1:0]  cpu_size = 2'd0;
   logic [31:0] cpu_wdata = 32'd0;
   logic        cpu_ready, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic [7:0]  pd_out, pd_in;
   logic        pd_oe;
   logic [4:0]  st_in = 5'b10101;
   logic        n_strobe, n_autolf, n_init, n_selin, n_write, n_dstrb, n_astrb;
   logic        n_wait;

   always #2.5 clk = ~clk;

   epp_port_ctrl #(.BUS_W(32), .TMO_CYCLES(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
      .pd_in(pd_in), .st_in(st_in), .n_strobe(n_strobe), .n_autolf(n_autolf),
      .n_init(n_init), .n_selin(n_selin), .n_write(n_write), .n_dstrb(n_dstrb),
      .n_astrb(n_astrb), .n_wait(n_wait)
   );

   // peripheral model
   logic       mute = 1'b0;
   logic [7:0] rd_seq;
   logic [1:0] dly;
   logic       strb, prev_strb;
   int         strb_starts, log_n, pd_changes;
   logic [7:0] log_val [0:63];
   logic       log_adr [0:63];
   logic [7:0] prev_pd;

   assign strb  = !n_dstrb || !n_astrb;
   assign pd_in = rd_seq;

   always @(posedge clk) begin
      if (!rst_n) begin
         n_wait <= 1'b0; dly <= 2'd0; rd_seq <= 8'h3C;
         strb_starts <= 0; log_n <= 0; prev_strb <= 1'b0;
      end else begin
         prev_strb <= strb;
         if (strb && !prev_strb) strb_starts <= strb_starts + 1;
         if (!mute) begin
            if (strb && !n_wait) begin
               if (dly == 2'd2) begin
                  n_wait <= 1'b1; dly <= 2'd0;
                  if (!n_write) begin
                     log_val[log_n % 64] <= pd_out;
                     log_adr[log_n % 64] <= !n_astrb;
                     log_n <= log_n + 1;
                  end
               end else dly <= dly + 2'd1;
            end else if (!strb && n_wait) begin
               if (dly == 2'd2) begin
                  n_wait <= 1'b0; dly <= 2'd0;
                  if (n_write) rd_seq <= rd_seq + 8'h11;
               end else dly <= dly + 2'd1;
            end else dly <= 2'd0;
         end
      end
   end

   always @(posedge clk) begin
      prev_pd <= pd_out;
      if (!rst_n) pd_changes <= 0;
      else if (pd_out !== prev_pd) pd_changes <= pd_changes + 1;
   end

   int checks = 0, errors = 0;
   logic ready_after;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [2:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      while (!cpu_ready) @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      ready_after = cpu_ready;
      while (!cpu_rvalid) @(negedge clk);
      rd = cpu_rdata;
      @(negedge clk);
      check("R13 rvalid one cycle", {31'd0, cpu_rvalid}, 32'd0);
   endtask

   function automatic bit gate_w(input logic [5:0] c);
      return (c & 6'h2F) == 6'h04;
   endfunction
   function automatic bit gate_r(input logic [5:0] c);
      return (c & 6'h2F) == 6'h24;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [7:0]  s;
      int n0, p0;
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R13 ready after reset", {31'd0, cpu_ready}, 32'd1);
      check("R3 reset pins", {28'd0, n_strobe, n_autolf, n_init, n_selin}, 32'h0000000E);
      check("R3 reset oe", {31'd0, pd_oe}, 32'd1);
      check("R4 reset pd_out", {24'd0, pd_out}, 32'hFF);
      acc(1'b0, 3'd2, 2'd0, 0, rd); check("R2 reset ctrl readback", rd, 32'hCC);
      check("R13 ready low after accept", {31'd0, ready_after}, 32'd0);
      acc(1'b0, 3'd0, 2'd0, 0, rd); check("R4 reset data read", rd, 32'hFF);
      acc(1'b0, 3'd1, 2'd0, 0, rd); check("R5 status read", rd, 32'hA8);

      // unused locations
      for (int k = 5; k < 8; k++) begin
         acc(1'b0, 3'(k), 2'd0, 0, rd); check("R1 unused read", rd, 32'hFF);
      end
      acc(1'b1, 3'd6, 2'd0, 32'h00, rd);
      acc(1'b0, 3'd2, 2'd0, 0, rd); check("R1 unused write ignored", rd, 32'hCC);

      // control pins
      acc(1'b1, 3'd2, 2'd0, 32'h0B, rd);
      check("R3 pins 0x0B", {28'd0, n_strobe, n_autolf, n_init, n_selin}, 32'h0);
      acc(1'b1, 3'd2, 2'd0, 32'hFF, rd);
      acc(1'b0, 3'd2, 2'd0, 0, rd); check("R2 readback 0x3F", rd, 32'hFF);
      acc(1'b1, 3'd2, 2'd0, 32'h24, rd);
      check("R3 pins 0x24", {27'd0, pd_oe, n_strobe, n_autolf, n_init, n_selin}, 32'h0F);

      // data register
      acc(1'b0, 3'd0, 2'd0, 0, rd); check("R4 input read", rd, {24'd0, pd_in});
      acc(1'b1, 3'd2, 2'd0, 32'h04, rd);
      acc(1'b1, 3'd0, 2'd0, 32'h5A, rd);
      check("R4 pd_out", {24'd0, pd_out}, 32'h5A);
      p0 = pd_changes;
      acc(1'b1, 3'd0, 2'd0, 32'h5A, rd);
      check("R4 same value no pin change", pd_changes - p0, 0);
      acc(1'b0, 3'd0, 2'd0, 0, rd); check("R4 latch read", rd, 32'h5A);

      // write gate closed
      acc(1'b1, 3'd2, 2'd0, 32'h0C, rd);
      n0 = strb_starts;
      acc(1'b1, 3'd3, 2'd0, 32'h77, rd);
      acc(1'b1, 3'd4, 2'd2, 32'h11223344, rd);
      check("R6 gated write no strobe", strb_starts - n0, 0);

      // address write
      acc(1'b1, 3'd2, 2'd0, 32'h04, rd);
      n0 = log_n;
      acc(1'b1, 3'd3, 2'd2, 32'hABCDEF77, rd);
      check("R8 addr write count", log_n - n0, 1);
      check("R8 addr write value", {23'd0, log_adr[n0 % 64], log_val[n0 % 64]}, 32'h177);
      check("R4 pins restored", {24'd0, pd_out}, 32'h5A);

      // multi-byte writes
      n0 = log_n;
      acc(1'b1, 3'd4, 2'd2, 32'hA1B2C3D4, rd);
      check("R10 word write count", log_n - n0, 4);
      check("R10 word lanes", {log_val[n0 % 64], log_val[(n0+1) % 64],
            log_val[(n0+2) % 64], log_val[(n0+3) % 64]}, 32'hD4C3B2A1);
      check("R8 data strobe used", {31'd0, log_adr[n0 % 64]}, 32'd0);
      n0 = log_n;
      acc(1'b1, 3'd4, 2'd1, 32'hFFFF1234, rd);
      check("R10 half write", {16'd0, log_val[n0 % 64], log_val[(n0+1) % 64]}, 32'h3412);
      check("R10 half count", log_n - n0, 2);

      // read gate closed
      n0 = strb_starts;
      acc(1'b0, 3'd4, 2'd2, 0, rd); check("R7 gated word", rd, 32'hFFFFFFFF);
      acc(1'b0, 3'd4, 2'd1, 0, rd); check("R7 gated half", rd, 32'h0000FFFF);
      acc(1'b0, 3'd3, 2'd0, 0, rd); check("R7 gated byte", rd, 32'h000000FF);
      check("R7 no strobe", strb_starts - n0, 0);

      // reads
      acc(1'b1, 3'd2, 2'd0, 32'h24, rd);
      s = rd_seq;
      acc(1'b0, 3'd4, 2'd2, 0, rd);
      check("R10 word read lanes", rd, {s + 8'h33, s + 8'h22, s + 8'h11, s});
      s = rd_seq;
      acc(1'b0, 3'd3, 2'd0, 0, rd); check("R9 addr read", rd, {24'd0, s});

      // timeout
      mute = 1'b1;
      acc(1'b0, 3'd4, 2'd2, 0, rd); check("R11 aborted read", rd, 32'hFFFFFFFF);
      check("R11 strobe released", {30'd0, n_dstrb, n_astrb}, 32'd3);
      acc(1'b0, 3'd1, 2'd0, 0, rd); check("R11 flag set", rd & 32'h1, 32'h1);
      acc(1'b1, 3'd1, 2'd0, 32'hFE, rd);
      acc(1'b0, 3'd1, 2'd0, 0, rd); check("R12 zero write keeps flag", rd, 32'hA9);
      acc(1'b1, 3'd1, 2'd0, 32'h01, rd);
      acc(1'b0, 3'd1, 2'd0, 0, rd); check("R12 flag cleared", rd, 32'hA8);
      acc(1'b1, 3'd2, 2'd0, 32'h04, rd);
      n0 = strb_starts;
      acc(1'b1, 3'd4, 2'd2, 32'h01020304, rd);
      check("R11 remaining bytes dropped", strb_starts - n0, 1);
      acc(1'b0, 3'd1, 2'd0, 0, rd); check("R11 write timeout flag", rd, 32'hA9);
      acc(1'b1, 3'd1, 2'd0, 32'h01, rd);
      mute = 1'b0;

      // randomised gate checks
      for (int it = 0; it < 80; it++) begin
         logic [5:0] c;
         logic [7:0] v;
         int pick;
         c = 6'($urandom % 64);
         pick = int'($urandom % 3);
         if (pick == 0) c = 6'h04;
         else if (pick == 1) c = 6'h24;
         else if ($urandom % 2 == 0) c = c ^ 6'(1 << ($urandom % 6)) & 6'h2F | 6'h04;
         acc(1'b1, 3'd2, 2'd0, {26'd0, c}, rd);
         acc(1'b0, 3'd2, 2'd0, 0, rd); check("R2 random readback", rd, {24'd0, 2'b11, c});
         if ($urandom % 2 == 0) begin
            v = 8'($urandom);
            n0 = log_n;
            acc(1'b1, 3'd4, 2'd0, {24'd0, v}, rd);
            if (gate_w(c)) begin
               check("R6 random write ran", log_n - n0, 1);
               check("R8 random write value", {24'd0, log_val[n0 % 64]}, {24'd0, v});
            end else check("R6 random write gated", log_n - n0, 0);
         end else begin
            s = rd_seq;
            acc(1'b0, 3'd4, 2'd0, 0, rd);
            check("R7 random read", rd, gate_r(c) ? {24'd0, s} : 32'hFF);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule